// File: doc/BRIEF.md
# Single-Line Interrupt Trigger Controller

This block conditions one external interrupt wire for a parent interrupt controller. The raw wire is brought into the clock domain through a synchronizer chain. It is then sensed according to a programmable trigger type: low level, high level, falling edge or rising edge. A sensed event is latched in a sticky pending flag. The single interrupt output is a registered copy of pending gated by an enable bit.

Software reaches the block through a simple single-cycle bus with byte addresses. The bus has three registers: a control word that holds the trigger type, a pending word, and an enable word. Pending is acknowledged by writing a one, and the same acknowledge serves as both edge acknowledge and level end-of-interrupt. A parameter places the enable word at one of two offsets so that one body of RTL can serve two register layouts. The input is expected to idle high, and the synchronizer resets to that level.

Top module: `nmi_trig_ctrl`

## Requirements
- R1: The control register at offset 0x00 stores and reads back all 32 bits. Only bits [1:0] select the trigger type: 0 = low level, 1 = falling edge, 2 = high level, 3 = rising edge. Bits above bit 1 have no effect on sensing.
- R2: In the level types, pending sets while the synchronized input is at the active level, and it sets again on the cycle after an acknowledge if the level is still active.
- R3: In the edge types, pending sets only when the synchronized input moves in the selected direction. A steady input never sets pending.
- R4: The pending flag reads at bit 0 of offset 0x04. Writing a word with bit 0 = 1 clears it. Writing a word with bit 0 = 0 leaves it unchanged.
- R5: When a new event and a clearing write fall in the same cycle, the event wins and pending stays set.
- R6: Bit 0 of the enable register gates the output. This register is at offset 0x08, or at 0x34 when ALT_ENABLE_MAP = 1. irq_out is a registered copy of pending AND enable. Pending still collects events while enable is 0.
- R7: A change on nmi_in is visible in pending after the third rising clock edge. irq_out follows one edge later.
- R8: After reset, control, pending, enable and irq_out are all zero.
- R9: Addresses other than the three mapped ones read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_in | input | 1 | Raw external interrupt line, asynchronous, idles high |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, same cycle |
| irq_out | output | 1 | Interrupt toward the parent controller |

## Verification
The hardest situation to reach from the ports is a new edge landing in exactly the cycle that carries an acknowledge write. The stimulus first leaves pending set in rising-edge mode. It then raises nmi_in at a falling clock edge and counts two rising edges through the synchronizer. It issues the clearing write so that it takes effect on the third edge, and reads pending back to confirm it is still set. The rest of the stimulus sweeps every trigger type against every before/after input level, both masked and unmasked, and compares against an arithmetic prediction.

// File: rtl/nmi_trig_pkg.sv
package nmi_trig_pkg;

   // Trigger-type field encoding (control register bits [1:0]).
   typedef enum logic [1:0] {
      SENSE_LOW  = 2'd0,
      SENSE_FALL = 2'd1,
      SENSE_HIGH = 2'd2,
      SENSE_RISE = 2'd3
   } sense_e;

   // Byte offsets of the register words.
   localparam int unsigned OFS_CTRL  = 32'h00;
   localparam int unsigned OFS_PEND  = 32'h04;
   localparam int unsigned OFS_EN_A  = 32'h08;
   localparam int unsigned OFS_EN_B  = 32'h34;

   localparam int unsigned MODE_BITS = 2;

   function automatic logic is_edge_type(input sense_e m);
      return m[0];
   endfunction

endpackage

// File: rtl/nmi_trig_sync.sv
module nmi_trig_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("nmi_trig_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], raw_i};
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/nmi_trig_detect.sv
module nmi_trig_detect
   import nmi_trig_pkg::*;
#(
   parameter logic RST_VAL = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   sync_i,
   input  sense_e mode_i,
   output logic   event_o
);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= RST_VAL;
      end else begin
         prev_q <= sync_i;
      end
   end

   logic went_up, went_down;
   assign went_up   = sync_i & ~prev_q;
   assign went_down = ~sync_i & prev_q;

   always_comb begin
      unique case (mode_i)
         SENSE_LOW:  event_o = ~sync_i;
         SENSE_HIGH: event_o = sync_i;
         SENSE_FALL: event_o = went_down;
         SENSE_RISE: event_o = went_up;
         default:    event_o = 1'b0;
      endcase
   end

   // R3: an edge type never reports an event on a steady input
   a_r3_steady_no_edge : assert property (@(posedge clk) disable iff (!rst_n)
      (is_edge_type(mode_i) && $stable(sync_i)) |-> !event_o);

endmodule

// File: rtl/nmi_trig_regs.sv
module nmi_trig_regs
   import nmi_trig_pkg::*;
#(
   parameter int unsigned ADDR_W         = 8,
   parameter int unsigned DATA_W         = 32,
   parameter bit          ALT_ENABLE_MAP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_we_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   input  logic              event_i,
   output sense_e            mode_o,
   output logic              pend_o,
   output logic              en_o
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
   localparam logic [ADDR_W-1:0] A_EN_A = ADDR_W'(OFS_EN_A);
   localparam logic [ADDR_W-1:0] A_EN_B = ADDR_W'(OFS_EN_B);

   if (ADDR_W < 6) begin : g_bad_addr
      $error("nmi_trig_regs: ADDR_W must reach offset 0x34");
   end
   if (DATA_W < MODE_BITS) begin : g_bad_data
      $error("nmi_trig_regs: DATA_W too narrow for the type field");
   end

   logic ctrl_hit, pend_hit, en_hit;
   assign ctrl_hit = (bus_addr_i == A_CTRL);
   assign pend_hit = (bus_addr_i == A_PEND);

   if (ALT_ENABLE_MAP) begin : g_en_alt
      assign en_hit = (bus_addr_i == A_EN_B);
   end else begin : g_en_std
      assign en_hit = (bus_addr_i == A_EN_A);
   end

   logic [DATA_W-1:0] ctrl_q;
   logic              pend_q;
   logic              en_q;
   logic              clr_wr;

   assign clr_wr = bus_we_i & pend_hit & bus_wdata_i[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (bus_we_i && ctrl_hit) begin
         ctrl_q <= bus_wdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
      end else if (bus_we_i && en_hit) begin
         en_q <= bus_wdata_i[0];
      end
   end

   // New event has priority over an acknowledge in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (event_i) begin
         pend_q <= 1'b1;
      end else if (clr_wr) begin
         pend_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata_o = '0;
      if (ctrl_hit) begin
         bus_rdata_o = ctrl_q;
      end else if (pend_hit) begin
         bus_rdata_o[0] = pend_q;
      end else if (en_hit) begin
         bus_rdata_o[0] = en_q;
      end
   end

   assign mode_o = sense_e'(ctrl_q[MODE_BITS-1:0]);
   assign pend_o = pend_q;
   assign en_o   = en_q;

   // R4: an acknowledge without a competing event drops pending
   a_r4_clear_drops : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && !event_i) |=> !pend_o);

   // R4: pending is sticky until acknowledged
   a_r4_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o && !clr_wr) |=> pend_o);

   // R5: an event always leaves pending set, acknowledge or not
   a_r5_event_wins : assert property (@(posedge clk) disable iff (!rst_n)
      event_i |=> pend_o);

   // R6: a write to the enable word takes bit 0 of the data
   a_r6_enable_write : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we_i && en_hit) |=> (en_o == $past(bus_wdata_i[0])));

endmodule

// File: rtl/nmi_trig_ctrl.sv
module nmi_trig_ctrl
   import nmi_trig_pkg::*;
#(
   parameter int unsigned ADDR_W         = 8,
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter logic        IDLE_LEVEL     = 1'b1,
   parameter bit          ALT_ENABLE_MAP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nmi_in,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_out
);

   logic   sync_w;
   logic   event_w;
   logic   pend_w;
   logic   en_w;
   sense_e mode_w;

   nmi_trig_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (IDLE_LEVEL)
   ) i_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (nmi_in),
      .sync_o (sync_w)
   );

   nmi_trig_detect #(
      .RST_VAL (IDLE_LEVEL)
   ) i_detect (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync_i  (sync_w),
      .mode_i  (mode_w),
      .event_o (event_w)
   );

   nmi_trig_regs #(
      .ADDR_W         (ADDR_W),
      .DATA_W         (DATA_W),
      .ALT_ENABLE_MAP (ALT_ENABLE_MAP)
   ) i_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr_i  (bus_addr),
      .bus_we_i    (bus_we),
      .bus_wdata_i (bus_wdata),
      .bus_rdata_o (bus_rdata),
      .event_i     (event_w),
      .mode_o      (mode_w),
      .pend_o      (pend_w),
      .en_o        (en_w)
   );

   logic irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else begin
         irq_q <= pend_w & en_w;
      end
   end

   assign irq_out = irq_q;

   // R6: a masked cycle is followed by a quiet output
   a_r6_masked_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      !en_w |=> !irq_out);

   // R6: the output only rises after pending was seen
   a_r6_rise_from_pending : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out) |-> $past(pend_w));

endmodule

// File: tb/test_nmi_trig_ctrl.sv
`timescale 1ns/1ps
module test_nmi_trig_ctrl;

   localparam logic [7:0] A_CTRL = 8'h00;
   localparam logic [7:0] A_PEND = 8'h04;
   localparam logic [7:0] A_EN   = 8'h08;
   localparam logic [7:0] A_ALT  = 8'h34;
   localparam logic [7:0] A_IDLE = 8'hF0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        nmi_in = 1'b1;
   logic [7:0]  bus_addr = A_IDLE;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   nmi_trig_ctrl i_nmi_trig_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .nmi_in    (nmi_in),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_out   (irq_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = A_IDLE;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #2;
      d = bus_rdata;
      bus_addr = A_IDLE;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic predict(input int m, input int a, input int b);
      logic act;
      act = m[1];
      if (m[0]) return (a != b) && (b[0] == act);
      return (a[0] == act) || (b[0] == act);
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      settle(3);
      rst_n = 1'b1;
      settle(1);

      // R8: reset state
      rd(A_CTRL, d); chk("R8 ctrl after reset", d, 0);
      rd(A_PEND, d); chk("R8 pending after reset", d, 0);
      rd(A_EN, d);   chk("R8 enable after reset", d, 0);
      chk("R8 irq_out after reset", {31'b0, irq_out}, 0);

      // R1 R2 R3 R6: sweep every type, every transition, masked and unmasked
      for (int en = 0; en < 2; en++) begin
         wr(A_EN, en);
         for (int m = 0; m < 4; m++) begin
            for (int a = 0; a < 2; a++) begin
               for (int b = 0; b < 2; b++) begin
                  logic e;
                  wr(A_CTRL, m);
                  nmi_in = a[0];
                  settle(5);
                  wr(A_PEND, 1);
                  nmi_in = b[0];
                  settle(5);
                  e = predict(m, a, b);
                  rd(A_PEND, d);
                  chk($sformatf("%s type %0d %0d->%0d", m[0] ? "R3" : "R2", m, a, b), d, {31'b0, e});
                  chk($sformatf("R6 irq_out en %0d type %0d %0d->%0d", en, m, a, b),
                      {31'b0, irq_out}, {31'b0, e & en[0]});
               end
            end
         end
      end

      // R1: full control word reads back; upper bits do not steer sensing
      wr(A_EN, 0);
      nmi_in = 1'b1;
      wr(A_CTRL, 32'hC3A5F0F2);
      rd(A_CTRL, d); chk("R1 ctrl readback", d, 32'hC3A5F0F2);
      settle(4);
      rd(A_PEND, d); chk("R1 high level with upper bits", d, 1);
      wr(A_CTRL, 32'hFFFFFFFC);
      wr(A_PEND, 1);
      settle(4);
      rd(A_PEND, d); chk("R1 low level ignores upper ones", d, 0);

      // R4: write of zero bit 0 keeps pending
      wr(A_CTRL, 3);
      nmi_in = 1'b0; settle(4);
      nmi_in = 1'b1; settle(4);
      wr(A_PEND, 0);
      rd(A_PEND, d); chk("R4 write 0 keeps pending", d, 1);
      wr(A_PEND, 32'hFFFFFFFE);
      rd(A_PEND, d); chk("R4 bit0 clear word keeps pending", d, 1);
      wr(A_PEND, 1);
      rd(A_PEND, d); chk("R4 write 1 clears", d, 0);

      // R6 R9: masked accumulation, then alternate offset is unmapped here
      nmi_in = 1'b0; settle(4);
      nmi_in = 1'b1; settle(4);
      chk("R6 masked output low", {31'b0, irq_out}, 0);
      wr(A_ALT, 1);
      settle(2);
      chk("R9 write to unmapped leaves mask", {31'b0, irq_out}, 0);
      rd(A_ALT, d);  chk("R9 unmapped 0x34 reads zero", d, 0);
      rd(8'h0C, d);  chk("R9 unmapped 0x0C reads zero", d, 0);
      wr(A_EN, 1);
      rd(A_EN, d);   chk("R6 enable readback", d, 1);
      settle(1);
      chk("R6 accumulated pending drives output", {31'b0, irq_out}, 1);
      wr(A_PEND, 1);
      settle(2);
      chk("R6 output drops after ack", {31'b0, irq_out}, 0);

      // R7: latency through synchronizer, detector and output flop
      nmi_in = 1'b0; settle(4);
      wr(A_PEND, 1);
      nmi_in = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rd(A_PEND, d); chk("R7 pending not yet set after two edges", d, 0);
      @(negedge clk);
      rd(A_PEND, d); chk("R7 pending set after third edge", d, 1);
      chk("R7 irq_out still low", {31'b0, irq_out}, 0);
      @(negedge clk);
      chk("R7 irq_out one edge later", {31'b0, irq_out}, 1);

      // R5: new edge coincides with acknowledge
      nmi_in = 1'b0; settle(4);
      rd(A_PEND, d); chk("R5 precondition pending set", d, 1);
      nmi_in = 1'b1;
      @(negedge clk);
      @(negedge clk);
      bus_addr = A_PEND; bus_we = 1'b1; bus_wdata = 32'h1;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = A_IDLE;
      rd(A_PEND, d); chk("R5 event wins over ack", d, 1);
      wr(A_PEND, 1);
      rd(A_PEND, d); chk("R5 later ack clears", d, 0);

      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule